// File: doc/BRIEF.md
# Retrying Bridge Upstream Slave with Read Prefetch

This block is the upstream slave side of a bus-to-bus bridge. It carries one transaction at a time and refuses every other request with a retry until that transaction has been fully carried to the downstream side. A write is captured into a one-entry posted buffer and acknowledged at once. It is then forwarded as a command on a simple downstream master interface, and the block stays busy until the downstream side reports completion.

A read cannot be answered at once. The first read to an address starts a downstream prefetch and is told to retry. When the prefetch result returns, the block holds the data, or the error, until the upstream master retries with the same address. That request is served from the buffer. If no matching read arrives within `PF_TIMEOUT` cycles, the held result is thrown away and the block becomes idle again. The upstream responses are combinational in the cycle the request is presented. The bus-timeout-suppress output is never used.

Top module: `upb_bridge_slave`

## Requirements
- R1: After reset the block is idle. The `up_ack`, `up_err_ack`, `up_retry` and `dn_cmd_valid` outputs are low, and `up_rdata` is zero.
- R2: In any cycle with `up_req` high, exactly one of `up_ack`, `up_err_ack` and `up_retry` is high. With `up_req` low, all three are low.
- R3: A write (`up_rnw`=0) presented while the block is idle is answered with `up_ack` in the same cycle. From the next cycle on, `dn_cmd_valid` is high with `dn_cmd_rnw`=0 and carries the captured address, byte enables and data. These stay stable until a cycle with `dn_cmd_ready` high.
- R4: After a write is accepted, every request is answered with retry until the cycle in which `dn_done` is high. This includes a write to the same address. From the next cycle on, the block is idle again.
- R5: A read (`up_rnw`=1) presented while the block is idle is answered with retry. From the next cycle on, `dn_cmd_valid` is high with `dn_cmd_rnw`=1 and the read address and byte enables.
- R6: While a prefetch is outstanding, before `dn_done`, every request is answered with retry, including a read to the prefetch address.
- R7: After the prefetch returns with `dn_err`=0, a read to the prefetch address is answered with `up_ack` and `up_rdata` equal to the returned `dn_rdata`, and the block becomes idle.
- R8: After the prefetch returns with `dn_err`=1, a read to the prefetch address is answered with `up_err_ack` instead of `up_ack`, with `up_rdata` zero, and the block becomes idle.
- R9: While a prefetch result is held, a read to a different address and any write are answered with retry. They leave the held result unchanged.
- R10: The held result can be collected during the `PF_TIMEOUT` cycles that follow the `dn_done` cycle. In the cycle after those, the result and any stored error have been discarded and the block is idle. A read then starts a new prefetch.
- R11: `up_tout_sup` is always low, and `up_rdata` is zero in every cycle without `up_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream request valid this cycle |
| up_rnw | input | 1 | 1 = read, 0 = write |
| up_addr | input | ADDR_W | Upstream address |
| up_be | input | BE_W | Upstream byte enables |
| up_wdata | input | DATA_W | Upstream write data |
| up_ack | output | 1 | Transfer acknowledge |
| up_err_ack | output | 1 | Error acknowledge |
| up_retry | output | 1 | Retry, master must come back later |
| up_rdata | output | DATA_W | Read data, zero unless acknowledging |
| up_tout_sup | output | 1 | Bus timeout suppress, tied inactive |
| dn_cmd_valid | output | 1 | Downstream command pending |
| dn_cmd_ready | input | 1 | Downstream takes the command |
| dn_cmd_rnw | output | 1 | Command direction, 1 = read |
| dn_cmd_addr | output | ADDR_W | Command address |
| dn_cmd_be | output | BE_W | Command byte enables |
| dn_cmd_wdata | output | DATA_W | Command write data |
| dn_done | input | 1 | Downstream completion pulse |
| dn_err | input | 1 | Completion carried an error |
| dn_rdata | input | DATA_W | Read data returned with completion |

## Verification
The hardest cases to reach from the ports depend on how many cycles pass between prefetch completion and the matching retry. One case is a match in the last cycle of the hold window. The other is a request one cycle later, which must find the block idle and start a fresh fetch. The stimulus sweeps that delay over every offset from zero to `PF_TIMEOUT` with both clean and errored prefetch results. On the longer offsets it puts a foreign read and a write into the hold window before the match. After a flush of an errored result it fetches again and expects a clean acknowledge.

// File: rtl/upb_pkg.sv
package upb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WPOST = 2'd1,
        ST_FETCH = 2'd2,
        ST_HOLD  = 2'd3
    } upb_state_e;

    typedef struct packed {
        logic ack;
        logic err_ack;
        logic retry;
    } upb_resp_t;

    function automatic upb_resp_t upb_resp_none();
        upb_resp_t r;
        r.ack     = 1'b0;
        r.err_ack = 1'b0;
        r.retry   = 1'b0;
        return r;
    endfunction

    function automatic upb_resp_t upb_resp_retry();
        upb_resp_t r;
        r       = upb_resp_none();
        r.retry = 1'b1;
        return r;
    endfunction

    function automatic upb_resp_t upb_resp_done(input logic failed);
        upb_resp_t r;
        r         = upb_resp_none();
        r.ack     = !failed;
        r.err_ack = failed;
        return r;
    endfunction

endpackage

// File: rtl/upb_cmd_reg.sv
module upb_cmd_reg #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              in_rnw,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              ready,
    output logic              valid,
    output logic              cmd_rnw,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BE_W-1:0]   cmd_be,
    output logic [DATA_W-1:0] cmd_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid     <= 1'b0;
            cmd_rnw   <= 1'b0;
            cmd_addr  <= '0;
            cmd_be    <= '0;
            cmd_wdata <= '0;
        end else if (load) begin
            valid     <= 1'b1;
            cmd_rnw   <= in_rnw;
            cmd_addr  <= in_addr;
            cmd_be    <= in_be;
            cmd_wdata <= in_rnw ? '0 : in_wdata;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/upb_pf_buf.sv
module upb_pf_buf #(
    parameter int DATA_W     = 32,
    parameter int PF_TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_err,
    input  logic              clear,
    input  logic              holding,
    output logic [DATA_W-1:0] data,
    output logic              err,
    output logic              expired
);

    localparam int TW = $clog2(PF_TIMEOUT + 1);
    localparam logic [TW-1:0] LAST = TW'(PF_TIMEOUT - 1);

    logic [TW-1:0] age;

    assign expired = (age == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            err  <= 1'b0;
            age  <= '0;
        end else if (fill) begin
            data <= fill_data;
            err  <= fill_err;
            age  <= '0;
        end else if (clear) begin
            data <= '0;
            err  <= 1'b0;
            age  <= '0;
        end else if (holding && !expired) begin
            age <= age + 1'b1;
        end
    end

endmodule

// File: rtl/upb_ctrl.sv
module upb_ctrl
    import upb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_err,
    input  logic              pf_expired,
    input  logic              dn_done,
    output upb_state_e        state,
    output upb_resp_t         resp,
    output logic              cmd_load,
    output logic              pf_fill,
    output logic              pf_clear
);

    upb_state_e nxt;
    logic       hit;

    assign hit = req && rnw && (addr == pf_addr);

    always_comb begin
        nxt      = state;
        resp     = upb_resp_none();
        cmd_load = 1'b0;
        pf_fill  = 1'b0;
        pf_clear = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    cmd_load = 1'b1;
                    if (rnw) begin
                        resp = upb_resp_retry();
                        nxt  = ST_FETCH;
                    end else begin
                        resp = upb_resp_done(1'b0);
                        nxt  = ST_WPOST;
                    end
                end
            end
            ST_WPOST: begin
                if (req) resp = upb_resp_retry();
                if (dn_done) nxt = ST_IDLE;
            end
            ST_FETCH: begin
                if (req) resp = upb_resp_retry();
                if (dn_done) begin
                    pf_fill = 1'b1;
                    nxt     = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hit) begin
                    resp     = upb_resp_done(pf_err);
                    pf_clear = 1'b1;
                    nxt      = ST_IDLE;
                end else begin
                    if (req) resp = upb_resp_retry();
                    if (pf_expired) begin
                        pf_clear = 1'b1;
                        nxt      = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/upb_bridge_slave.sv
module upb_bridge_slave
    import upb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BE_W       = DATA_W / 8,
    parameter int PF_TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_req,
    input  logic              up_rnw,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [BE_W-1:0]   up_be,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_ack,
    output logic              up_err_ack,
    output logic              up_retry,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_tout_sup,
    output logic              dn_cmd_valid,
    input  logic              dn_cmd_ready,
    output logic              dn_cmd_rnw,
    output logic [ADDR_W-1:0] dn_cmd_addr,
    output logic [BE_W-1:0]   dn_cmd_be,
    output logic [DATA_W-1:0] dn_cmd_wdata,
    input  logic              dn_done,
    input  logic              dn_err,
    input  logic [DATA_W-1:0] dn_rdata
);

    upb_state_e        st;
    upb_resp_t         resp;
    logic              cmd_load;
    logic              pf_fill;
    logic              pf_clear;
    logic [DATA_W-1:0] pf_data;
    logic              pf_err;
    logic              pf_expired;

    upb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (up_req),
        .rnw        (up_rnw),
        .addr       (up_addr),
        .pf_addr    (dn_cmd_addr),
        .pf_err     (pf_err),
        .pf_expired (pf_expired),
        .dn_done    (dn_done),
        .state      (st),
        .resp       (resp),
        .cmd_load   (cmd_load),
        .pf_fill    (pf_fill),
        .pf_clear   (pf_clear)
    );

    upb_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd_load),
        .in_rnw    (up_rnw),
        .in_addr   (up_addr),
        .in_be     (up_be),
        .in_wdata  (up_wdata),
        .ready     (dn_cmd_ready),
        .valid     (dn_cmd_valid),
        .cmd_rnw   (dn_cmd_rnw),
        .cmd_addr  (dn_cmd_addr),
        .cmd_be    (dn_cmd_be),
        .cmd_wdata (dn_cmd_wdata)
    );

    upb_pf_buf #(.DATA_W(DATA_W), .PF_TIMEOUT(PF_TIMEOUT)) u_pf (
        .clk       (clk),
        .rst       (rst),
        .fill      (pf_fill),
        .fill_data (dn_rdata),
        .fill_err  (dn_err),
        .clear     (pf_clear),
        .holding   (st == ST_HOLD),
        .data      (pf_data),
        .err       (pf_err),
        .expired   (pf_expired)
    );

    assign up_ack      = resp.ack;
    assign up_err_ack  = resp.err_ack;
    assign up_retry    = resp.retry;
    assign up_rdata    = resp.ack ? pf_data : '0;
    assign up_tout_sup = 1'b0;

endmodule

// File: rtl/upb_checks.sv
module upb_checks
    import upb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BE_W       = DATA_W / 8,
    parameter int PF_TIMEOUT = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              up_req,
    input logic              up_rnw,
    input logic              up_ack,
    input logic              up_err_ack,
    input logic              up_retry,
    input logic [DATA_W-1:0] up_rdata,
    input logic              up_tout_sup,
    input logic              dn_cmd_valid,
    input logic              dn_cmd_ready,
    input logic              dn_cmd_rnw,
    input logic [ADDR_W-1:0] dn_cmd_addr,
    input logic [BE_W-1:0]   dn_cmd_be,
    input logic [DATA_W-1:0] dn_cmd_wdata,
    input upb_state_e        st
);

    int unsigned hold_cnt;

    always_ff @(posedge clk) begin
        if (rst || st != ST_HOLD) hold_cnt <= 0;
        else                      hold_cnt <= hold_cnt + 1;
    end

    p_one_resp_r2: assert property (@(posedge clk) disable iff (rst)
        up_req |-> $countones({up_ack, up_err_ack, up_retry}) == 1);

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !up_req |-> !(up_ack || up_err_ack || up_retry));

    p_idle_write_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && up_req && !up_rnw) |-> up_ack);

    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (dn_cmd_valid && !dn_cmd_ready) |=> (dn_cmd_valid && $stable(dn_cmd_rnw)
            && $stable(dn_cmd_addr) && $stable(dn_cmd_be) && $stable(dn_cmd_wdata)));

    p_wpost_retry_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WPOST && up_req) |-> up_retry);

    p_idle_read_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && up_req && up_rnw) |=> (dn_cmd_valid && dn_cmd_rnw));

    p_fetch_retry_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH && up_req) |-> up_retry);

    p_hold_window_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |-> (hold_cnt < PF_TIMEOUT));

    p_tout_sup_r11: assert property (@(posedge clk) disable iff (rst)
        !up_tout_sup);

    p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !up_ack |-> (up_rdata == '0));

endmodule

bind upb_bridge_slave upb_checks #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .PF_TIMEOUT(PF_TIMEOUT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .up_req       (up_req),
    .up_rnw       (up_rnw),
    .up_ack       (up_ack),
    .up_err_ack   (up_err_ack),
    .up_retry     (up_retry),
    .up_rdata     (up_rdata),
    .up_tout_sup  (up_tout_sup),
    .dn_cmd_valid (dn_cmd_valid),
    .dn_cmd_ready (dn_cmd_ready),
    .dn_cmd_rnw   (dn_cmd_rnw),
    .dn_cmd_addr  (dn_cmd_addr),
    .dn_cmd_be    (dn_cmd_be),
    .dn_cmd_wdata (dn_cmd_wdata),
    .st           (st)
);

// File: tb/sim_upb_bridge_slave.sv
`timescale 1ns/1ps
module sim_upb_bridge_slave;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int BW = 2;
    localparam int TO = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          up_req = 1'b0;
    logic          up_rnw = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic [BW-1:0] up_be = '0;
    logic [DW-1:0] up_wdata = '0;
    logic          up_ack, up_err_ack, up_retry, up_tout_sup;
    logic [DW-1:0] up_rdata;
    logic          dn_cmd_valid, dn_cmd_rnw;
    logic          dn_cmd_ready = 1'b1;
    logic [AW-1:0] dn_cmd_addr;
    logic [BW-1:0] dn_cmd_be;
    logic [DW-1:0] dn_cmd_wdata;
    logic          dn_done = 1'b0;
    logic          dn_err = 1'b0;
    logic [DW-1:0] dn_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic          s_ack, s_err, s_retry;
    logic [DW-1:0] s_rdata;

    always #2.5 clk = ~clk;

    upb_bridge_slave #(.ADDR_W(AW), .DATA_W(DW), .BE_W(BW), .PF_TIMEOUT(TO)) u0 (
        .clk(clk), .rst(rst), .up_req(up_req), .up_rnw(up_rnw), .up_addr(up_addr),
        .up_be(up_be), .up_wdata(up_wdata), .up_ack(up_ack), .up_err_ack(up_err_ack),
        .up_retry(up_retry), .up_rdata(up_rdata), .up_tout_sup(up_tout_sup),
        .dn_cmd_valid(dn_cmd_valid), .dn_cmd_ready(dn_cmd_ready), .dn_cmd_rnw(dn_cmd_rnw),
        .dn_cmd_addr(dn_cmd_addr), .dn_cmd_be(dn_cmd_be), .dn_cmd_wdata(dn_cmd_wdata),
        .dn_done(dn_done), .dn_err(dn_err), .dn_rdata(dn_rdata)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a, a ^ 8'hA5};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    // one request cycle; responses sampled before the edge, returns just after it
    task automatic do_req(input logic rnw, input logic [AW-1:0] a, input logic [BW-1:0] be,
                          input logic [DW-1:0] wd);
        @(negedge clk);
        up_req = 1'b1; up_rnw = rnw; up_addr = a; up_be = be; up_wdata = wd;
        #1;
        s_ack = up_ack; s_err = up_err_ack; s_retry = up_retry; s_rdata = up_rdata;
        @(posedge clk);
        #0.5;
        up_req = 1'b0;
    endtask

    task automatic pulse_done(input logic e, input logic [DW-1:0] d);
        @(negedge clk);
        dn_done = 1'b1; dn_err = e; dn_rdata = d;
        @(posedge clk);
        #0.5;
        dn_done = 1'b0; dn_err = 1'b0; dn_rdata = '0;
    endtask

    // expect a pure retry
    task automatic exp_retry(input string req);
        chk_eq(req, {29'd0, s_ack, s_err, s_retry}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 responses", {29'd0, up_ack, up_err_ack, up_retry}, 32'd0);
        chk_eq("R1 cmd_valid", {31'd0, dn_cmd_valid}, 32'd0);
        chk_eq("R1 rdata", {16'd0, up_rdata}, 32'd0);
        chk_eq("R11 tout_sup", {31'd0, up_tout_sup}, 32'd0);

        // R2 no request, no response
        #1;
        chk_eq("R2 quiet", {29'd0, up_ack, up_err_ack, up_retry}, 32'd0);

        // write sweep
        for (int i = 0; i < 4; i++) begin
            logic [AW-1:0] a;
            logic [BW-1:0] be;
            logic [DW-1:0] wd;
            a  = AW'(8'h10 + i * 8'h13);
            be = BW'(i) | BW'(1);
            wd = 16'h1234 ^ DW'(i * 16'h0F1);
            dn_cmd_ready = (i != 0);
            do_req(1'b0, a, be, wd);
            chk_eq("R3 write ack", {29'd0, s_ack, s_err, s_retry}, 32'd4);
            chk_eq("R3 cmd valid", {31'd0, dn_cmd_valid}, 32'd1);
            chk_eq("R3 cmd rnw", {31'd0, dn_cmd_rnw}, 32'd0);
            chk_eq("R3 cmd addr", {24'd0, dn_cmd_addr}, {24'd0, a});
            chk_eq("R3 cmd be", {30'd0, dn_cmd_be}, {30'd0, be});
            chk_eq("R3 cmd wdata", {16'd0, dn_cmd_wdata}, {16'd0, wd});
            if (i == 0) begin
                repeat (2) @(posedge clk);
                #0.5;
                chk_eq("R3 held valid", {31'd0, dn_cmd_valid}, 32'd1);
                chk_eq("R3 held wdata", {16'd0, dn_cmd_wdata}, {16'd0, wd});
                dn_cmd_ready = 1'b1;
            end
            @(posedge clk);
            #0.5;
            chk_eq("R3 cmd taken", {31'd0, dn_cmd_valid}, 32'd0);
            do_req(1'b0, a, be, wd);
            exp_retry("R4 same-address write");
            do_req(1'b1, a, be, '0);
            exp_retry("R4 read during write");
            chk_eq("R4 no new cmd", {31'd0, dn_cmd_valid}, 32'd0);
            pulse_done(i[0], '0);
        end

        // read sweep over hold offsets and error flag
        for (int h = 0; h <= TO; h++) begin
            for (int e = 0; e < 2; e++) begin
                logic [AW-1:0] a;
                a = AW'(8'h40 + h * 8'h06 + e);
                do_req(1'b1, a, 2'b11, '0);
                exp_retry("R5 first read retried");
                chk_eq("R5 cmd valid", {31'd0, dn_cmd_valid}, 32'd1);
                chk_eq("R5 cmd rnw", {31'd0, dn_cmd_rnw}, 32'd1);
                chk_eq("R5 cmd addr", {24'd0, dn_cmd_addr}, {24'd0, a});
                do_req(1'b1, a, 2'b11, '0);
                exp_retry("R6 match during fetch");
                do_req(1'b0, a, 2'b01, 16'hBEEF);
                exp_retry("R6 write during fetch");
                pulse_done(e[0], pat(a));
                if (h >= 2) begin
                    do_req(1'b1, a ^ 8'h80, 2'b11, '0);
                    exp_retry("R9 foreign read in hold");
                    do_req(1'b0, a, 2'b11, 16'h5555);
                    exp_retry("R9 write in hold");
                    repeat (h - 2) @(posedge clk);
                end else begin
                    repeat (h) @(posedge clk);
                end
                do_req(1'b1, a, 2'b11, '0);
                if (h < TO) begin
                    if (e == 0) begin
                        chk_eq("R7 data ack", {29'd0, s_ack, s_err, s_retry}, 32'd4);
                        chk_eq("R7 rdata", {16'd0, s_rdata}, {16'd0, pat(a)});
                    end else begin
                        chk_eq("R8 error ack", {29'd0, s_ack, s_err, s_retry}, 32'd2);
                        chk_eq("R8 rdata zero", {16'd0, s_rdata}, 32'd0);
                    end
                    chk_eq("R7 no cmd after serve", {31'd0, dn_cmd_valid}, 32'd0);
                end else begin
                    exp_retry("R10 expired, refetch");
                    chk_eq("R10 new fetch issued", {31'd0, dn_cmd_valid}, 32'd1);
                    chk_eq("R10 new fetch addr", {24'd0, dn_cmd_addr}, {24'd0, a});
                    @(posedge clk);
                    pulse_done(1'b0, pat(a) ^ 16'h00FF);
                    do_req(1'b1, a, 2'b11, '0);
                    chk_eq("R10 flushed error gone", {29'd0, s_ack, s_err, s_retry}, 32'd4);
                    chk_eq("R10 fresh data", {16'd0, s_rdata}, {16'd0, pat(a) ^ 16'h00FF});
                end
            end
        end

        @(negedge clk);
        chk_eq("R11 tout_sup end", {31'd0, up_tout_sup}, 32'd0);
        chk_eq("R2 idle end", {29'd0, up_ack, up_err_ack, up_retry}, 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule